// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with 64-bit memory-mapped access reach a separate 32-bit internal register bus. The host never touches the internal registers directly. It writes one packed command word that carries the operation, a 13-bit internal address and 32 bits of write data. The bridge performs exactly that one access on the internal bus with a request/acknowledge handshake. It then raises a completion flag in a status word, which also holds the returned read data. The host polls that status word until the flag is set.

A third, read-only word describes a serial peripheral master that sits next to the bridge: bit order, word width, chip-select count, clock polarity, clock phase and an identifier. Its values come from parameters. The serial master itself and whatever answers on the internal bus are outside this block.

Host reads are registered. The data appears one cycle after the read strobe, together with a one-cycle valid pulse. Only one internal access can be outstanding at a time.

Top module: `regbridge_top`

## Requirements
- R1: After synchronous reset, the status word reads as zero: flag clear, data zero. No internal request is active.
- R2: A read at byte offset 0x08 returns the descriptor word. Bit 1 is the bit order (0 = most significant bit first, 1 = least significant first). Bits 7:2 are the word width and bits 13:8 the chip-select count. Bit 14 is clock polarity, bit 15 is clock phase and bits 47:32 are the peripheral identifier. All other bits are zero. Host writes to this offset change nothing.
- R3: A host write to offset 0x10 is decoded as follows: bits 63:62 are the operation (1 = read, 2 = write), bits 44:32 the internal address and bits 31:0 the write data. When the bridge is idle, a read or write operation starts exactly one internal access at that address. A write access carries that data.
- R4: The status word at offset 0x18 holds read data in bits 31:0 and the completion flag in bit 32; bits 63:33 read as zero. Read data is captured on the acknowledge of a read access. A write access leaves the data field unchanged.
- R5: The internal request stays high, with address, data and direction stable, until the cycle the acknowledge is seen. In the following cycle the request is low and the completion flag is set.
- R6: An accepted command clears the completion flag in the cycle after the control write. The flag and the request are never high together.
- R7: Operation codes 0 and 3 start no internal access and leave the status word unchanged.
- R8: A control write that arrives while an access is outstanding is ignored. It starts no second access, and the outstanding access keeps its address and data.
- R9: A host read returns data one cycle after the read strobe, with a one-cycle valid pulse. Offsets other than 0x08, 0x10 and 0x18, and any offset not aligned to 8 bytes, read as zero. Host writes anywhere other than an aligned 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rvalid | output | 1 | Host read data valid, one cycle after host_rd |
| host_rdata | output | 64 | Host read data |
| ib_req | output | 1 | Internal bus request, held until acknowledged |
| ib_write | output | 1 | Internal bus direction, 1 = write |
| ib_addr | output | 13 | Internal bus register address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 32 | Internal bus read data, sampled with ib_ack |

## Verification
The request rises one cycle after the control write is sampled. With a responder that acknowledges L cycles after it first sees the request, the request is high for exactly L+2 sampled cycles. The bench counts this for two values of L. The completion flag becomes readable in the cycle after the acknowledge. A host read reflects the status as it stood at the edge that samples the strobe, so the bench never assumes a fixed poll count and polls until the flag is seen. Every host read is compared one cycle after its strobe, at the falling edge that follows the valid pulse. Ignored stimulus is judged at least five cycles later, from the responder's access count and from a fresh read of the status word.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;

    localparam int IB_AW   = 13;
    localparam int IB_DW   = 32;
    localparam int HOST_DW = 64;

    // word indices (byte offset / 8) of the host-visible registers
    localparam int WIDX_DESC   = 1;
    localparam int WIDX_CTRL   = 2;
    localparam int WIDX_STATUS = 3;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [16:0]       gap;
        logic [IB_AW-1:0]  addr;
        logic [IB_DW-1:0]  data;
    } ctrl_word_t;

    typedef struct packed {
        logic [30:0]       zero;
        logic              valid;
        logic [IB_DW-1:0]  data;
    } status_word_t;

    typedef struct packed {
        logic              write;
        logic [IB_AW-1:0]  addr;
        logic [IB_DW-1:0]  wdata;
    } ib_cmd_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DESC,
        SEL_CTRL,
        SEL_STATUS
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } seq_state_e;

    function automatic logic is_access(input op_e op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

    function automatic logic [HOST_DW-1:0] pack_desc(
        input logic        lsb_first,
        input logic [5:0]  word_bits,
        input logic [5:0]  cs_count,
        input logic        cpol,
        input logic        cpha,
        input logic [15:0] periph_id
    );
        logic [HOST_DW-1:0] v;
        v        = '0;
        v[1]     = lsb_first;
        v[7:2]   = word_bits;
        v[13:8]  = cs_count;
        v[14]    = cpol;
        v[15]    = cpha;
        v[47:32] = periph_id;
        return v;
    endfunction

endpackage

// File: rtl/regbridge_decode.sv
module regbridge_decode
    import regbridge_pkg::*;
#(
    parameter int                 HOST_AW   = 8,
    parameter logic [HOST_DW-1:0] DESC_WORD = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    input  status_word_t       status_word,
    output logic               ctrl_stb,
    output ctrl_word_t         ctrl_word,
    output logic               host_rvalid,
    output logic [HOST_DW-1:0] host_rdata
);

    localparam int IDX_W = HOST_AW - 3;

    reg_sel_e           sel;
    logic [HOST_DW-1:0] rd_mux;
    logic [16:0]        unused_gap;

    always_comb begin
        sel = SEL_NONE;
        if (host_addr[2:0] == 3'b000) begin
            if (host_addr[HOST_AW-1:3] == IDX_W'(WIDX_DESC))
                sel = SEL_DESC;
            else if (host_addr[HOST_AW-1:3] == IDX_W'(WIDX_CTRL))
                sel = SEL_CTRL;
            else if (host_addr[HOST_AW-1:3] == IDX_W'(WIDX_STATUS))
                sel = SEL_STATUS;
        end
    end

    assign ctrl_word  = ctrl_word_t'(host_wdata);
    assign ctrl_stb   = host_wr && (sel == SEL_CTRL);
    assign unused_gap = ctrl_word.gap;

    always_comb begin
        unique case (sel)
            SEL_DESC:   rd_mux = DESC_WORD;
            SEL_STATUS: rd_mux = HOST_DW'(status_word);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd)
                host_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/regbridge_seq.sv
module regbridge_seq
    import regbridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_stb,
    input  ctrl_word_t       ctrl_word,
    input  logic             ib_ack,
    output logic             ib_req,
    output ib_cmd_t          ib_cmd,
    output logic             start_o,
    output logic             done_o,
    output logic             done_rd_o
);

    seq_state_e state_q;
    ib_cmd_t    cmd_q;

    assign start_o   = (state_q == ST_IDLE) && ctrl_stb && is_access(ctrl_word.op);
    assign done_o    = (state_q == ST_WAIT) && ib_ack;
    assign done_rd_o = done_o && !cmd_q.write;
    assign ib_req    = (state_q == ST_WAIT);
    assign ib_cmd    = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_o) begin
                        cmd_q.write <= (ctrl_word.op == OP_WRITE);
                        cmd_q.addr  <= ctrl_word.addr;
                        cmd_q.wdata <= ctrl_word.data;
                        state_q     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (ib_ack)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/regbridge_status.sv
module regbridge_status
    import regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              done,
    input  logic              done_rd,
    input  logic [IB_DW-1:0]  rd_data,
    output status_word_t      status_word
);

    status_word_t sts_q;

    assign status_word = sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q.zero <= '0;
            if (start) begin
                sts_q.valid <= 1'b0;
            end else if (done) begin
                sts_q.valid <= 1'b1;
                if (done_rd)
                    sts_q.data <= rd_data;
            end
        end
    end

endmodule

// File: rtl/regbridge_top.sv
module regbridge_top
    import regbridge_pkg::*;
#(
    parameter int          HOST_AW       = 8,
    parameter bit          SPI_LSB_FIRST = 1'b0,
    parameter int          SPI_WORD_BITS = 32,
    parameter int          SPI_CS_COUNT  = 1,
    parameter bit          SPI_CPOL      = 1'b0,
    parameter bit          SPI_CPHA      = 1'b0,
    parameter logic [15:0] SPI_PERIPH_ID = 16'h1C2D
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic               host_rvalid,
    output logic [63:0]        host_rdata,
    output logic               ib_req,
    output logic               ib_write,
    output logic [12:0]        ib_addr,
    output logic [31:0]        ib_wdata,
    input  logic               ib_ack,
    input  logic [31:0]        ib_rdata
);

    localparam logic [HOST_DW-1:0] DESC_WORD = pack_desc(
        SPI_LSB_FIRST, 6'(SPI_WORD_BITS), 6'(SPI_CS_COUNT),
        SPI_CPOL, SPI_CPHA, SPI_PERIPH_ID);

    ctrl_word_t   ctrl_word;
    logic         ctrl_stb;
    status_word_t status_word;
    ib_cmd_t      ib_cmd;
    logic         start, done, done_rd;
    logic         sts_valid_w;
    logic [31:0]  sts_data_w;

    regbridge_decode #(
        .HOST_AW   (HOST_AW),
        .DESC_WORD (DESC_WORD)
    ) decode_i (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .status_word (status_word),
        .ctrl_stb    (ctrl_stb),
        .ctrl_word   (ctrl_word),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata)
    );

    regbridge_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .ctrl_stb  (ctrl_stb),
        .ctrl_word (ctrl_word),
        .ib_ack    (ib_ack),
        .ib_req    (ib_req),
        .ib_cmd    (ib_cmd),
        .start_o   (start),
        .done_o    (done),
        .done_rd_o (done_rd)
    );

    regbridge_status status_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .done        (done),
        .done_rd     (done_rd),
        .rd_data     (ib_rdata),
        .status_word (status_word)
    );

    assign ib_write    = ib_cmd.write;
    assign ib_addr     = ib_cmd.addr;
    assign ib_wdata    = ib_cmd.wdata;
    assign sts_valid_w = status_word.valid;
    assign sts_data_w  = status_word.data;

endmodule

// File: rtl/regbridge_chk.sv
module regbridge_chk #(
    parameter int HOST_AW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               host_wr,
    input logic               host_rd,
    input logic [HOST_AW-1:0] host_addr,
    input logic [63:0]        host_wdata,
    input logic               host_rvalid,
    input logic               ib_req,
    input logic               ib_write,
    input logic [12:0]        ib_addr,
    input logic [31:0]        ib_wdata,
    input logic               ib_ack,
    input logic [31:0]        ib_rdata,
    input logic               sts_valid,
    input logic [31:0]        sts_data
);

    logic ctrl_hit;
    logic op_go;
    assign ctrl_hit = host_wr && (host_addr == HOST_AW'('h10));
    assign op_go    = (host_wdata[63:62] == 2'd1) || (host_wdata[63:62] == 2'd2);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !ib_req && !sts_valid && (sts_data == 32'h0)); // R1

    AST_START_ONE: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit && op_go && !ib_req |=> ib_req && (ib_addr == $past(host_wdata[44:32]))); // R3

    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ib_req && ib_ack && !ib_write |=> sts_data == $past(ib_rdata)); // R4

    AST_WR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        ib_req && ib_ack && ib_write |=> $stable(sts_data)); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        ib_req && !ib_ack |=> ib_req && $stable(ib_addr) && $stable(ib_wdata) && $stable(ib_write)); // R5

    AST_ACK_DONE: assert property (@(posedge clk) disable iff (rst)
        ib_req && ib_ack |=> !ib_req && sts_valid); // R5

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit && op_go && !ib_req |=> !sts_valid); // R6

    AST_FLAG_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sts_valid && ib_req)); // R6

    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit && !op_go && !ib_req |=> !ib_req && $stable(sts_valid)); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit && ib_req && !ib_ack |=> ib_req && $stable(ib_addr) && $stable(ib_wdata)); // R8

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid); // R9

endmodule

bind regbridge_top regbridge_chk #(.HOST_AW(HOST_AW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .ib_req      (ib_req),
    .ib_write    (ib_write),
    .ib_addr     (ib_addr),
    .ib_wdata    (ib_wdata),
    .ib_ack      (ib_ack),
    .ib_rdata    (ib_rdata),
    .sts_valid   (sts_valid_w),
    .sts_data    (sts_data_w)
);

// File: tb/regbridge_top_tb_top.sv
module regbridge_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic        host_rvalid;
    logic [63:0] host_rdata;
    logic        ib_req, ib_write, ib_ack;
    logic [12:0] ib_addr;
    logic [31:0] ib_wdata, ib_rdata;

    always #10 clk = ~clk;

    regbridge_top dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .ib_req(ib_req), .ib_write(ib_write), .ib_addr(ib_addr),
        .ib_wdata(ib_wdata), .ib_ack(ib_ack), .ib_rdata(ib_rdata)
    );

    // responder model on the internal bus
    int          lat = 0;
    int          cnt;
    int          txn_cnt;
    int          req_cycles;
    logic [31:0] mem [32];

    always @(posedge clk) begin
        if (rst) begin
            ib_ack     <= 1'b0;
            ib_rdata   <= '0;
            cnt        <= 0;
            txn_cnt    <= 0;
            req_cycles <= 0;
            for (int i = 0; i < 32; i++) mem[i] <= '0;
        end else begin
            ib_ack <= 1'b0;
            if (ib_req) req_cycles <= req_cycles + 1;
            if (ib_req && ib_ack) txn_cnt <= txn_cnt + 1;
            if (ib_req && !ib_ack) begin
                if (cnt == lat) begin
                    ib_ack <= 1'b1;
                    cnt    <= 0;
                    if (ib_write) mem[ib_addr[6:2]] <= ib_wdata;
                    else          ib_rdata <= mem[ib_addr[6:2]];
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end

    // scoreboard
    typedef struct {
        logic [63:0] data;
        logic [63:0] mask;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    int   n_total = 0;
    int   n_fail  = 0;

    function automatic void check(input bit ok, input string tag,
                                  input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    always @(negedge clk) begin
        if (!rst && host_rvalid && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.mask != '0)
                check(((host_rdata ^ e.data) & e.mask) == '0, e.tag,
                      host_rdata & e.mask, e.data & e.mask);
        end
    end

    localparam logic [63:0] ALL   = '1;
    localparam logic [63:0] FLAG  = 64'h1_0000_0000;
    localparam logic [63:0] DESC  = 64'h0000_1C2D_0000_0180;

    task automatic host_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input logic [63:0] e,
                             input logic [63:0] m, input string tag,
                             output logic [63:0] v);
        exp_t it;
        it.data = e; it.mask = m; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic issue(input logic [1:0] op, input logic [12:0] a, input logic [31:0] d);
        host_write(8'h10, {op, 17'h0, a, d});
    endtask

    task automatic poll(output logic [63:0] v);
        v = '0;
        for (int i = 0; i < 100; i++) begin
            host_read(8'h18, '0, '0, "poll", v);
            if (v[32]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 64'h0, 64'h1);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        logic [63:0] v;
        int t0, r0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check(ib_req == 1'b0, "R1 req after reset", 64'(ib_req), 64'h0);
        host_read(8'h18, 64'h0, ALL, "R1 status after reset", v);
        // R2 descriptor
        host_read(8'h08, DESC, ALL, "R2 descriptor", v);
        // R9 read pulse
        check(host_rvalid == 1'b1, "R9 rvalid pulse", 64'(host_rvalid), 64'h1);

        // R3 write access, R5 latency with lat 0
        lat = 0; t0 = txn_cnt; r0 = req_cycles;
        issue(2'd2, 13'h0010, 32'hDEADBEEF);
        poll(v);
        check(v[32] == 1'b1, "R3 write completes", v, FLAG);
        check(mem[4] == 32'hDEADBEEF, "R3 write data landed", 64'(mem[4]), 64'hDEADBEEF);
        check(txn_cnt == t0 + 1, "R3 one access", 64'(txn_cnt - t0), 64'h1);
        check(req_cycles - r0 == 2, "R5 req length lat0", 64'(req_cycles - r0), 64'h2);

        // R4 read back
        issue(2'd1, 13'h0010, 32'h0);
        poll(v);
        host_read(8'h18, FLAG | 64'hDEADBEEF, ALL, "R4 read data", v);

        // R5 latency with lat 3, more patterns
        lat = 3; r0 = req_cycles;
        issue(2'd2, 13'h0020, 32'h12345678);
        poll(v);
        check(req_cycles - r0 == 5, "R5 req length lat3", 64'(req_cycles - r0), 64'h5);
        issue(2'd2, 13'h1FFC, 32'hCAFE0001);
        poll(v);
        issue(2'd1, 13'h1FFC, 32'h0);
        poll(v);
        host_read(8'h18, FLAG | 64'hCAFE0001, ALL, "R4 read top address", v);
        issue(2'd1, 13'h0020, 32'h0);
        poll(v);
        host_read(8'h18, FLAG | 64'h12345678, ALL, "R4 read second word", v);

        // R4 write leaves read data
        issue(2'd2, 13'h0030, 32'h0BADF00D);
        poll(v);
        host_read(8'h18, FLAG | 64'h12345678, ALL, "R4 write keeps data", v);
        check(mem[12] == 32'h0BADF00D, "R3 third write landed", 64'(mem[12]), 64'h0BADF00D);

        // R6 flag clears, R8 busy write ignored
        lat = 15; t0 = txn_cnt;
        issue(2'd1, 13'h0010, 32'h0);
        host_read(8'h18, 64'h0, FLAG, "R6 flag cleared", v);
        issue(2'd2, 13'h0040, 32'h55AA55AA);
        poll(v);
        check(txn_cnt == t0 + 1, "R8 single access", 64'(txn_cnt - t0), 64'h1);
        check(mem[16] == 32'h0, "R8 busy write dropped", 64'(mem[16]), 64'h0);
        host_read(8'h18, FLAG | 64'hDEADBEEF, ALL, "R8 first access kept", v);

        // R7 no-operation codes
        lat = 0; t0 = txn_cnt;
        issue(2'd0, 13'h0010, 32'h11111111);
        repeat (5) @(negedge clk);
        check(txn_cnt == t0 && !ib_req, "R7 op 0 starts nothing", 64'(txn_cnt - t0), 64'h0);
        host_read(8'h18, FLAG | 64'hDEADBEEF, ALL, "R7 op 0 status kept", v);
        issue(2'd3, 13'h0010, 32'h22222222);
        repeat (5) @(negedge clk);
        check(txn_cnt == t0 && !ib_req, "R7 op 3 starts nothing", 64'(txn_cnt - t0), 64'h0);
        host_read(8'h18, FLAG | 64'hDEADBEEF, ALL, "R7 op 3 status kept", v);

        // R9 and R2 ignored writes, unmapped reads
        host_write(8'h08, ALL);
        host_read(8'h08, DESC, ALL, "R2 descriptor read-only", v);
        host_write(8'h18, 64'h0);
        host_read(8'h18, FLAG | 64'hDEADBEEF, ALL, "R9 status write ignored", v);
        host_write(8'h14, {2'd2, 17'h0, 13'h0050, 32'h77777777});
        repeat (5) @(negedge clk);
        check(txn_cnt == t0 && mem[20] == 32'h0, "R9 misaligned ctrl ignored",
              64'(txn_cnt - t0), 64'h0);
        host_read(8'h00, 64'h0, ALL, "R9 offset 0 reads zero", v);
        host_read(8'h20, 64'h0, ALL, "R9 offset 0x20 reads zero", v);
        host_read(8'h0C, 64'h0, ALL, "R9 misaligned reads zero", v);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule